// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

The block lays a 64 by 64 monochrome cursor over a stream of 32-bit display pixels. The cursor image lives in a small byte memory. Each cursor row is 16 bytes long: eight bytes of an AND plane, then eight bytes of an XOR plane. Each pixel's pair of plane bits chooses one of four results: transparent, colour 0, colour 1, or the inverted background pixel.

The stream carries a valid strobe and horizontal and vertical sync. The block counts lines itself. A rising vertical sync makes the next line line 0, and every rising horizontal sync starts a new line. At each rising horizontal sync the sequencer copies the needed cursor row into a 16-byte line buffer, one byte per cycle, while the line is still blanked. The pixel path then runs with no memory access at all. It has a fixed latency of two cycles, and the sync and valid signals are delayed by the same amount.

Software writes position, image offset, colours, display limits and the enable bit through an 8-entry write-only register port. A lock bit freezes the register values the cursor uses, so several of them can be changed and then released together.

Top module: `curs_overlay`

## Requirements
- R1: After reset `outValid`, `outHsync`, `outVsync` and `outData` are all 0.
- R2: Each input pixel appears on the outputs exactly two cycles later, with `outValid`/`outHsync`/`outVsync` delayed by the same two cycles. A pixel outside the cursor window is passed through unchanged.
- R3: Inside the window, a pixel whose AND bit is 0 is replaced. The output is {colour1, 8'hFF} when its XOR bit is 1 and {colour0, 8'hFF} when it is 0. Colour 0 is register 4 and colour 1 is register 5, 24 bits each taken from data[23:0].
- R4: Inside the window, a pixel whose AND bit is 1 gives the bitwise complement of the background when its XOR bit is 1, and the unchanged background when its XOR bit is 0.
- R5: Cursor row r, where r = line − Y, is read from byte address offset + 16·r. Bytes 0..7 are the AND plane and bytes 8..15 are the XOR plane. Column c uses bit 7−(c mod 8) of byte c/8, so bit 7 of byte 0 is the leftmost pixel.
- R6: The window on a line requires three things: the enable bit (register 0, bit 30) is 1, the line lies in Y..Y+63, and the line is not greater than the last-line value in register 7 (bits [11:0]).
- R7: Horizontally the window covers pixel X..X+63. A pixel whose x is at or beyond the display width in register 6 (bits [13:0]) is never altered, so drawing does not spill past the right edge.
- R8: Register 2 takes X from bits [29:16] and Y from bits [11:0], and all other bits except bit 31 are dropped. Register 1 takes the byte offset, and its low four bits are ignored, so the offset is 16-byte aligned.
- R9: Bit 31 written to register 1, 2 or 3 sets the lock, and bit 31 clear in those writes releases it. While the lock is set, position, offset and colour writes are stored but not used, and on release they all take effect together. Register 3 (hotspot) acts only on the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index 0..7 |
| regWrData | input | 32 | Register write data |
| memWrEn | input | 1 | Cursor image memory write strobe |
| memWrAddr | input | AW (11) | Image byte address |
| memWrData | input | 8 | Image byte |
| pixValid | input | 1 | Input pixel valid |
| pixHsync | input | 1 | Input horizontal sync, active high |
| pixVsync | input | 1 | Input vertical sync, active high |
| pixData | input | 32 | Background pixel |
| outValid | output | 1 | Output pixel valid |
| outHsync | output | 1 | Delayed horizontal sync |
| outVsync | output | 1 | Delayed vertical sync |
| outData | output | 32 | Composited pixel |

## Verification
The assertions check four properties on every cycle:
- The two-cycle alignment of valid.
- Unchanged pass-through of any pixel on a line without a cursor hit, and of any pixel at or past the right edge.
- That a line latched while the cursor is disabled never gets a hit.
- That the values the cursor uses hold still while the lock is set.

The other behaviours need real image content and a reference model, so only the bench scenarios show them: the four-way AND/XOR mix, the most-significant-bit-first column order, the row address arithmetic, the top and bottom window edges against Y and the last-line limit, the register field masking, and the deferred release of locked writes.

// File: rtl/curs_pkg.sv
`timescale 1ns/1ps
package curs_pkg;
  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_OFFSET = 3'd1;
  localparam logic [2:0] REG_POS    = 3'd2;
  localparam logic [2:0] REG_HOT    = 3'd3;
  localparam logic [2:0] REG_CLR0   = 3'd4;
  localparam logic [2:0] REG_CLR1   = 3'd5;
  localparam logic [2:0] REG_HWIDTH = 3'd6;
  localparam logic [2:0] REG_VEND   = 3'd7;

  localparam int ROW_BYTES = 16;
  localparam int CUR_DIM   = 64;

  typedef struct packed {
    logic       lineLatch;
    logic       bufWr;
    logic [3:0] bufIdx;
  } fetchStrobe_t;
endpackage

// File: rtl/curs_mem.sv
`timescale 1ns/1ps
module curs_mem #(
  parameter int BYTES = 2048,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData
);
  logic [7:0] store [BYTES];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    if (rdEn) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/curs_ctrl.sv
`timescale 1ns/1ps
module curs_ctrl
  import curs_pkg::*;
#(
  parameter int AW    = 11,
  parameter int X_W   = 14,
  parameter int Y_W   = 12,
  parameter int COL_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  input  logic             pixHsync,
  input  logic             pixVsync,
  output logic             memRdEn,
  output logic [AW-1:0]    memRdAddr,
  output fetchStrobe_t     strb,
  output logic [Y_W-1:0]   lineNum,
  output logic             curEn,
  output logic [X_W-1:0]   actX,
  output logic [Y_W-1:0]   actY,
  output logic [Y_W-1:0]   vEnd,
  output logic [X_W-1:0]   hWidth,
  output logic [COL_W-1:0] actC0,
  output logic [COL_W-1:0] actC1
);
  localparam int OFF_W = AW - 4;

  logic             hsPrev, vsPrev, hsRise, vsRise;
  logic [Y_W-1:0]   lineNext;
  logic [5:0]       rowQ;
  logic [3:0]       fetchCnt;
  logic             busy;
  logic             rdValQ;
  logic [3:0]       rdIdxQ;
  logic             lockQ;
  logic [OFF_W-1:0] offS, actOff;
  logic [X_W-1:0]   posXS;
  logic [Y_W-1:0]   posYS;
  logic [COL_W-1:0] c0S, c1S;

  assign hsRise = pixHsync & ~hsPrev;
  assign vsRise = pixVsync & ~vsPrev;
  assign lineNum = lineNext;

  assign strb.lineLatch = hsRise;
  assign strb.bufWr     = rdValQ;
  assign strb.bufIdx    = rdIdxQ;

  assign memRdEn   = busy;
  assign memRdAddr = {actOff + OFF_W'(rowQ), fetchCnt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsPrev   <= 1'b0;
      vsPrev   <= 1'b0;
      lineNext <= '0;
      rowQ     <= '0;
      fetchCnt <= '0;
      busy     <= 1'b0;
      rdValQ   <= 1'b0;
      rdIdxQ   <= '0;
      lockQ    <= 1'b0;
      curEn    <= 1'b0;
      offS     <= '0;
      posXS    <= '0;
      posYS    <= '0;
      c0S      <= '0;
      c1S      <= '0;
      hWidth   <= '0;
      vEnd     <= '0;
      actOff   <= '0;
      actX     <= '0;
      actY     <= '0;
      actC0    <= '0;
      actC1    <= '0;
    end else begin
      hsPrev <= pixHsync;
      vsPrev <= pixVsync;

      if (vsRise)      lineNext <= '0;
      else if (hsRise) lineNext <= lineNext + 1'b1;

      if (hsRise) begin
        rowQ     <= 6'(lineNext - actY);
        fetchCnt <= '0;
        busy     <= 1'b1;
      end else if (busy) begin
        fetchCnt <= fetchCnt + 1'b1;
        if (fetchCnt == 4'd15) busy <= 1'b0;
      end
      rdValQ <= busy;
      rdIdxQ <= fetchCnt;

      if (regWrEn) begin
        case (regAddr)
          REG_CTRL:   curEn <= regWrData[30];
          REG_OFFSET: begin
            offS  <= regWrData[AW-1:4];
            lockQ <= regWrData[31];
          end
          REG_POS: begin
            posXS <= regWrData[16 +: X_W];
            posYS <= regWrData[Y_W-1:0];
            lockQ <= regWrData[31];
          end
          REG_HOT:    lockQ  <= regWrData[31];
          REG_CLR0:   c0S    <= regWrData[COL_W-1:0];
          REG_CLR1:   c1S    <= regWrData[COL_W-1:0];
          REG_HWIDTH: hWidth <= regWrData[X_W-1:0];
          REG_VEND:   vEnd   <= regWrData[Y_W-1:0];
          default: ;
        endcase
      end

      if (!lockQ) begin
        actOff <= offS;
        actX   <= posXS;
        actY   <= posYS;
        actC0  <= c0S;
        actC1  <= c1S;
      end
    end
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> ($stable(actX) && $stable(actY) && $stable(actOff) &&
               $stable(actC0) && $stable(actC1))); // R9
endmodule

// File: rtl/curs_datapath.sv
`timescale 1ns/1ps
module curs_datapath
  import curs_pkg::*;
#(
  parameter int X_W   = 14,
  parameter int Y_W   = 12,
  parameter int COL_W = 24,
  parameter int PIX_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  fetchStrobe_t     strb,
  input  logic [7:0]       memRdData,
  input  logic [Y_W-1:0]   lineNum,
  input  logic             curEn,
  input  logic [X_W-1:0]   actX,
  input  logic [Y_W-1:0]   actY,
  input  logic [Y_W-1:0]   vEnd,
  input  logic [X_W-1:0]   hWidth,
  input  logic [COL_W-1:0] actC0,
  input  logic [COL_W-1:0] actC1,
  input  logic             pixValid,
  input  logic             pixHsync,
  input  logic             pixVsync,
  input  logic [PIX_W-1:0] pixData,
  output logic             outValid,
  output logic             outHsync,
  output logic             outVsync,
  output logic [PIX_W-1:0] outData
);
  localparam int FILL_W = PIX_W - COL_W;

  logic [CUR_DIM-1:0] andBits, xorBits;
  logic               lineHit;
  logic [Y_W-1:0]     lineDelta;
  logic               hitNow;
  logic [X_W-1:0]     xCnt, col;
  logic               inWin;

  logic               s1Valid, s1Hs, s1Vs, s1Hit, s1And, s1Xor;
  logic [PIX_W-1:0]   s1Data;
  logic [PIX_W-1:0]   mixed;

  assign lineDelta = lineNum - actY;
  assign hitNow = curEn && (lineNum >= actY) && (lineDelta < Y_W'(CUR_DIM)) &&
                  (lineNum <= vEnd);

  assign col   = xCnt - actX;
  assign inWin = lineHit && (xCnt >= actX) && (col < X_W'(CUR_DIM)) && (xCnt < hWidth);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      andBits <= '0;
      xorBits <= '0;
      lineHit <= 1'b0;
    end else begin
      if (strb.lineLatch) lineHit <= hitNow;
      if (strb.bufWr) begin
        for (int j = 0; j < 8; j++) begin
          if (!strb.bufIdx[3]) andBits[{strb.bufIdx[2:0], 3'(j)}] <= memRdData[7-j];
          else                 xorBits[{strb.bufIdx[2:0], 3'(j)}] <= memRdData[7-j];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         xCnt <= '0;
    else if (pixHsync) xCnt <= '0;
    else if (pixValid) xCnt <= xCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Hs    <= 1'b0;
      s1Vs    <= 1'b0;
      s1Hit   <= 1'b0;
      s1And   <= 1'b0;
      s1Xor   <= 1'b0;
      s1Data  <= '0;
    end else begin
      s1Valid <= pixValid;
      s1Hs    <= pixHsync;
      s1Vs    <= pixVsync;
      s1Hit   <= inWin;
      s1And   <= andBits[col[5:0]];
      s1Xor   <= xorBits[col[5:0]];
      s1Data  <= pixData;
    end
  end

  always_comb begin
    if (!s1Hit)     mixed = s1Data;
    else if (s1And) mixed = s1Xor ? ~s1Data : s1Data;
    else            mixed = {(s1Xor ? actC1 : actC0), {FILL_W{1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outHsync <= 1'b0;
      outVsync <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= s1Valid;
      outHsync <= s1Hs;
      outVsync <= s1Vs;
      outData  <= mixed;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> ##1 outValid); // R2
  AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> ##1 !outValid); // R2
  AST_PASS_NOLINE: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !lineHit) |=> ##1 (outData == $past(pixData, 2))); // R2
  AST_CLIP_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && (xCnt >= hWidth)) |=> ##1 (outData == $past(pixData, 2))); // R7
  AST_DISABLED_NOHIT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lineLatch && !curEn) |=> !lineHit); // R6
endmodule

// File: rtl/curs_overlay.sv
`timescale 1ns/1ps
module curs_overlay
  import curs_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int X_W       = 14,
  parameter int Y_W       = 12,
  parameter int COL_W     = 24,
  parameter int PIX_W     = 32,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  input  logic             memWrEn,
  input  logic [AW-1:0]    memWrAddr,
  input  logic [7:0]       memWrData,
  input  logic             pixValid,
  input  logic             pixHsync,
  input  logic             pixVsync,
  input  logic [PIX_W-1:0] pixData,
  output logic             outValid,
  output logic             outHsync,
  output logic             outVsync,
  output logic [PIX_W-1:0] outData
);
  fetchStrobe_t     strb;
  logic             memRdEn;
  logic [AW-1:0]    memRdAddr;
  logic [7:0]       memRdData;
  logic [Y_W-1:0]   lineNum, actY, vEnd;
  logic [X_W-1:0]   actX, hWidth;
  logic             curEn;
  logic [COL_W-1:0] actC0, actC1;

  curs_mem #(.BYTES(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk), .wrEn(memWrEn), .wrAddr(memWrAddr), .wrData(memWrData),
    .rdEn(memRdEn), .rdAddr(memRdAddr), .rdData(memRdData)
  );

  curs_ctrl #(.AW(AW), .X_W(X_W), .Y_W(Y_W), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pixHsync(pixHsync), .pixVsync(pixVsync),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .strb(strb), .lineNum(lineNum),
    .curEn(curEn), .actX(actX), .actY(actY), .vEnd(vEnd), .hWidth(hWidth),
    .actC0(actC0), .actC1(actC1)
  );

  curs_datapath #(.X_W(X_W), .Y_W(Y_W), .COL_W(COL_W), .PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memRdData(memRdData),
    .lineNum(lineNum), .curEn(curEn), .actX(actX), .actY(actY), .vEnd(vEnd),
    .hWidth(hWidth), .actC0(actC0), .actC1(actC1), .pixValid(pixValid),
    .pixHsync(pixHsync), .pixVsync(pixVsync), .pixData(pixData),
    .outValid(outValid), .outHsync(outHsync), .outVsync(outVsync),
    .outData(outData)
  );
endmodule

// File: tb/curs_overlay_bench.sv
`timescale 1ns/1ps
module curs_overlay_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        memWrEn = 1'b0;
  logic [10:0] memWrAddr = '0;
  logic [7:0]  memWrData = '0;
  logic        pixValid = 1'b0, pixHsync = 1'b0, pixVsync = 1'b0;
  logic [31:0] pixData = '0;
  logic        outValid, outHsync, outVsync;
  logic [31:0] outData;

  curs_overlay u_curs_overlay (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .pixValid(pixValid), .pixHsync(pixHsync),
    .pixVsync(pixVsync), .pixData(pixData), .outValid(outValid),
    .outHsync(outHsync), .outVsync(outVsync), .outData(outData)
  );

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  string scenTag = "";

  logic [7:0] img [2048];
  bit showLine [128];
  bit mEn = 0;
  int mX = 0, mY = 0, mOff = 0, mHW = 80, mVEnd = 200;
  logic [23:0] mC0 = '0, mC1 = '0;

  function automatic logic [7:0] imgByte(int a);
    logic [7:0] v;
    v = 8'(a * 37 + (a >> 4) * 11 + 5);
    return v ^ (((a & 8) != 0) ? 8'h3C : 8'h0F);
  endfunction

  function automatic logic [31:0] expPix(int x, int y, logic [31:0] bg, output string tag);
    int row, col;
    logic a, b;
    if (!mEn || y < mY || y > mY + 63 || y > mVEnd) begin tag = "R6"; return bg; end
    if (x >= mHW) begin tag = "R7"; return bg; end
    if (x < mX || x > mX + 63) begin tag = "R2"; return bg; end
    row = y - mY; col = x - mX;
    a = img[(mOff + row * 16 + col / 8) % 2048][7 - col % 8];
    b = img[(mOff + row * 16 + 8 + col / 8) % 2048][7 - col % 8];
    if (!a) begin tag = "R3 R5"; return {(b ? mC1 : mC0), 8'hFF}; end
    tag = "R4 R5";
    return b ? ~bg : bg;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic loadImage();
    for (int a = 0; a < 2048; a++) begin
      img[a] = imgByte(a);
      @(negedge clk); memWrEn = 1; memWrAddr = 11'(a); memWrData = img[a];
    end
    @(negedge clk); memWrEn = 0;
  endtask

  task automatic doLine(int y);
    string t;
    @(negedge clk); pixHsync = 1;
    @(negedge clk);
    @(negedge clk); pixHsync = 0;
    repeat (20) @(negedge clk);
    if (showLine[y]) begin
      for (int x = 0; x < mHW + 4; x++) begin
        pixValid = 1;
        pixData = 32'h1357_0000 ^ (32'(x) << 8) ^ 32'(y * 3 + 1);
        expQ.push_back(expPix(x, y, pixData, t));
        tagQ.push_back({t, scenTag});
        @(negedge clk);
      end
      pixValid = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic frame(int lastLine);
    @(negedge clk); pixVsync = 1;
    @(negedge clk); pixVsync = 0;
    repeat (3) @(negedge clk);
    for (int y = 0; y <= lastLine; y++) doLine(y);
    for (int y = 0; y < 128; y++) showLine[y] = 0;
  endtask

  // Scoreboard monitor: pops one expected item per valid output pixel.
  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      if (expQ.size() == 0) check(0, "R2 unexpected pixel", outData, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outData === e, t, outData, e);
      end
    end
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int y = 0; y < 128; y++) showLine[y] = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(outValid == 0 && outHsync == 0 && outVsync == 0, "R1 sideband", {29'b0, outValid, outHsync, outVsync}, 32'h0);
    check(outData == 0, "R1 data", outData, 32'h0);

    loadImage();
    regWr(3'd6, 32'd80);   mHW = 80;
    regWr(3'd7, 32'd200);  mVEnd = 200;
    regWr(3'd4, 32'hAB12_3456); mC0 = 24'h12_3456;
    regWr(3'd5, 32'h00FE_DCBA); mC1 = 24'hFE_DCBA;
    regWr(3'd1, 32'h0000_0047); mOff = 32'h40;   // R8: low bits dropped
    regWr(3'd2, 32'h000A_0003); mX = 10; mY = 3;
    repeat (4) @(negedge clk);

    // R6: cursor disabled, everything passes
    showLine[3] = 1; showLine[10] = 1;
    frame(10);

    // R3 R4 R5 R6: enabled, top/bottom edges of window
    regWr(3'd0, 32'h4000_0000); mEn = 1;
    showLine[2] = 1; showLine[3] = 1; showLine[4] = 1; showLine[40] = 1;
    showLine[66] = 1; showLine[67] = 1;
    frame(67);

    // R8 R7: junk bits in position, cursor crosses the right edge
    scenTag = " R8";
    regWr(3'd2, 32'h4028_F004); mX = 40; mY = 4;
    showLine[4] = 1; showLine[5] = 1; showLine[67] = 1; showLine[68] = 1;
    frame(68);

    // R6: last-line limit
    scenTag = " vend";
    regWr(3'd7, 32'd6); mVEnd = 6;
    showLine[5] = 1; showLine[6] = 1; showLine[7] = 1;
    frame(7);
    regWr(3'd7, 32'd200); mVEnd = 200;

    // R9: locked writes are held back
    scenTag = " R9 locked";
    regWr(3'd2, 32'h8014_000A);
    regWr(3'd4, 32'h0055_AA11);
    regWr(3'd1, 32'h8000_0100);
    regWr(3'd5, 32'h0000_0F0F);
    showLine[4] = 1; showLine[5] = 1; showLine[10] = 1;
    frame(10);

    // R9: release through hotspot register, all values land together
    scenTag = " R9 released";
    regWr(3'd3, 32'h0000_0000);
    mX = 20; mY = 10; mC0 = 24'h55_AA11; mC1 = 24'h00_0F0F; mOff = 32'h100;
    repeat (4) @(negedge clk);
    showLine[9] = 1; showLine[10] = 1; showLine[40] = 1; showLine[73] = 1; showLine[74] = 1;
    frame(74);

    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R2 outstanding pixels", 32'(expQ.size()), 32'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule